// File: doc/BRIEF.md
# Multi-Mode Timer with Polarity Select

A single 16-bit timer channel that runs in one of eight modes, chosen by a three-bit mode field. These modes are one-shot, continuous, external-event counting, single-output PWM, capture, compare, gated and capture/compare. A reload value sets the terminal count. A second compare value sets the PWM switch point. A one-bit polarity input takes a different meaning in each mode. It can select the output's resting level, the input edge that is counted or captured, the input level that lets counting proceed, or the edge that starts a capture/compare run.

Configuration arrives as a register-style port: an enable write strobe with its data bit, plus mode, polarity, reload and compare values. The external timer input is synchronized inside the block. The block drives a timer output pin, a capture readback register, a one-cycle interrupt pulse and the current enable state. Mode and polarity are set while the timer is stopped and held while it runs.

Top module: `mode_timer`

## Requirements
- R1: While the enable is 0, other than the one-cycle one-shot pulse of R3, `tout_o` equals `pol_i`. A change of `pol_i` shows on `tout_o` without a clock edge.
- R2: Mode codes: 0 one-shot, 1 continuous, 2 event counter, 3 PWM, 4 capture, 5 compare, 6 gated, 7 capture/compare. Writing enable 1 while stopped loads the count with 1 on that clock edge. A counting step taken while the count equals `reload_i` is a reload. A reload restarts the count at 1 and raises `irq_o` for one cycle after that edge. In free-running modes, reloads therefore occur every `reload_i` cycles.
- R3: In one-shot mode, the edge that performs the reload clears the enable. For the following cycle only, `tout_o` shows the inverse of `pol_i`, and it then returns to `pol_i`.
- R4: In continuous, compare, counter, capture, gated and capture/compare modes, `tout_o` starts at `pol_i` when the timer is enabled and inverts on every reload.
- R5: In counter mode, the count advances only on input edges: rising edges when `pol_i`=0 and falling edges when `pol_i`=1.
- R6: In PWM mode, `tout_o` starts at the inverse of `pol_i`. It goes to `pol_i` on the edge where the count equals `cmp_i`, and it returns to the inverse level on reload.
- R7: In capture mode, the selected edge (rising for `pol_i`=0, falling for 1) loads the current count into `cap_o` and pulses `irq_o`. The other edge does nothing. A change on `tin_i` takes effect on the third rising clock edge after it.
- R8: In gated mode with `pol_i`=0, the count advances only while the synchronized input is high, and `irq_o` pulses on its falling edge. With `pol_i`=1, both sense levels are reversed. While the gate is closed, the count holds its value.
- R9: In capture/compare mode, the count stays at 1 until the first selected edge and advances every cycle after it. That first edge does not capture. Each later selected edge captures the count into `cap_o` and pulses `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_we_i | input | 1 | Enable write strobe |
| en_d_i | input | 1 | Enable value written when `en_we_i` is high |
| mode_i | input | 3 | Mode code (see R2) |
| pol_i | input | 1 | Polarity select |
| reload_i | input | 16 | Terminal count |
| cmp_i | input | 16 | PWM switch count |
| tin_i | input | 1 | External timer input, asynchronous |
| en_o | output | 1 | Current enable state |
| tout_o | output | 1 | Timer output pin |
| cap_o | output | 16 | Captured count |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The checker assumes that `mode_i`, `pol_i`, `reload_i` and `cmp_i` change only while the timer is stopped, and that `reload_i` is nonzero. The stimulus therefore writes all configuration in the same cycle as the enable write and changes polarity only between runs. Input transitions are spaced at least four clocks apart, so that each edge passes the synchronizer and is acted on before the next one arrives. Every expected event time is computed from the enable cycle and the three-edge input latency.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  typedef enum logic [2:0] {
    M_ONESHOT = 3'd0,
    M_CONT    = 3'd1,
    M_COUNTER = 3'd2,
    M_PWM     = 3'd3,
    M_CAPTURE = 3'd4,
    M_COMPARE = 3'd5,
    M_GATED   = 3'd6,
    M_CAPCMP  = 3'd7
  } tmr_mode_e;
endpackage

// File: rtl/mtmr_sync.sv
module mtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/mtmr_count.sv
module mtmr_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  assign wrap_o = adv_i && (cnt_q == top_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= CNT_ONE;
    else if (wrap_o)  cnt_q <= CNT_ONE;
    else if (adv_i)   cnt_q <= cnt_q + CNT_ONE;
endmodule

// File: rtl/mtmr_out.sv
module mtmr_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic init_lvl_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic wrap_i,
  input  logic match_i,
  input  logic oneshot_i,
  input  logic pwm_i,
  output logic tout_o
);
  logic lvl_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (start_i) begin
      lvl_q <= init_lvl_i;
    end else if (en_i) begin
      if (wrap_i) begin
        if (pwm_i)           lvl_q <= ~pol_i;
        else if (!oneshot_i) lvl_q <= ~lvl_q;
      end else if (match_i) begin
        lvl_q <= pol_i;
      end
    end

  // one-shot: inverse level for the single cycle after reload
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= en_i && wrap_i && oneshot_i;

  assign tout_o = (en_i ? lvl_q : pol_i) ^ pulse_q;
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mtmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         en_d_i,
  input  logic [2:0]   mode_i,
  input  logic         pol_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] cmp_i,
  input  logic         tin_i,
  output logic         en_o,
  output logic         tout_o,
  output logic [W-1:0] cap_o,
  output logic         irq_o
);
  tmr_mode_e    mode;
  logic         en_q, started_q, irq_q;
  logic [W-1:0] cap_q, cnt_q;
  logic         start, adv, wrap, pwm_match;
  logic         in_lvl, in_rise, in_fall;
  logic         sel_edge, opp_edge, gate_open;
  logic         cap_ev, gate_ev;

  assign mode  = tmr_mode_e'(mode_i);
  assign start = en_we_i && en_d_i && !en_q;

  mtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tin_i),
    .lvl_o  (in_lvl),
    .rise_o (in_rise),
    .fall_o (in_fall)
  );

  assign sel_edge  = pol_i ? in_fall : in_rise;
  assign opp_edge  = pol_i ? in_rise : in_fall;
  assign gate_open = in_lvl ^ pol_i;

  always_comb begin
    unique case (mode)
      M_COUNTER: adv = sel_edge;
      M_GATED:   adv = gate_open;
      M_CAPCMP:  adv = started_q;
      default:   adv = 1'b1;
    endcase
    adv = adv && en_q;
  end

  mtmr_count #(.W(W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .adv_i  (adv),
    .top_i  (reload_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  assign cap_ev = en_q && sel_edge &&
                  ((mode == M_CAPTURE) || (mode == M_CAPCMP && started_q));
  assign gate_ev   = en_q && (mode == M_GATED) && opp_edge;
  assign pwm_match = adv && (mode == M_PWM) && (cnt_q == cmp_i);

  // enable write wins over the one-shot self-clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          en_q <= 1'b0;
    else if (en_we_i)                     en_q <= en_d_i;
    else if (wrap && mode == M_ONESHOT)   en_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                    started_q <= 1'b0;
    else if (start)                                 started_q <= 1'b0;
    else if (en_q && mode == M_CAPCMP && sel_edge)  started_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cap_q <= '0;
    else if (cap_ev) cap_q <= cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap || cap_ev || gate_ev;

  mtmr_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .init_lvl_i ((mode == M_PWM) ? ~pol_i : pol_i),
    .en_i       (en_q),
    .pol_i      (pol_i),
    .wrap_i     (wrap),
    .match_i    (pwm_match),
    .oneshot_i  (mode == M_ONESHOT),
    .pwm_i      (mode == M_PWM),
    .tout_o     (tout_o)
  );

  assign en_o  = en_q;
  assign cap_o = cap_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_we_i,
  input logic [2:0]   mode_i,
  input logic         pol_i,
  input logic [W-1:0] reload_i,
  input logic [W-1:0] cmp_i,
  input logic         en_o,
  input logic         tout_o,
  input logic [W-1:0] cap_o,
  input logic         irq_o,
  input logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  assert_idle_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !$past(en_o)) |-> (tout_o == pol_i));

  assert_reload_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && mode_i == 3'd1 && cnt_q == reload_i && !en_we_i) |=> (cnt_q == CNT_ONE && irq_o));

  assert_oneshot_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_o) && mode_i == 3'd0 && !$past(en_we_i)) |-> (tout_o != pol_i && irq_o));

  assert_reload_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && (mode_i == 3'd1 || mode_i == 3'd5) && cnt_q == reload_i && !en_we_i)
      |=> (tout_o != $past(tout_o)));

  assert_pwm_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && mode_i == 3'd3 && cnt_q == cmp_i && cnt_q != reload_i && !en_we_i)
      |=> (tout_o == pol_i));

  assert_capture_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_o) |-> irq_o);
endmodule

bind mode_timer mode_timer_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_we_i  (en_we_i),
  .mode_i   (mode_i),
  .pol_i    (pol_i),
  .reload_i (reload_i),
  .cmp_i    (cmp_i),
  .en_o     (en_o),
  .tout_o   (tout_o),
  .cap_o    (cap_o),
  .irq_o    (irq_o),
  .cnt_q    (cnt_q)
);

// File: tb/mode_timer_test.sv
module mode_timer_test;
  localparam int PERIOD = 10;
  localparam int F_TOUT = 0, F_IRQ = 1, F_CAP = 2, F_EN = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_we_i = 1'b0, en_d_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        pol_i = 1'b0;
  logic [15:0] reload_i = 16'd1, cmp_i = 16'd0;
  logic        tin_i = 1'b0;
  logic        en_o, tout_o, irq_o;
  logic [15:0] cap_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    fld;
    int    val;
    string req;
  } exp_t;
  exp_t exp_q[$];

  mode_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_we_i(en_we_i), .en_d_i(en_d_i),
    .mode_i(mode_i), .pol_i(pol_i), .reload_i(reload_i), .cmp_i(cmp_i),
    .tin_i(tin_i), .en_o(en_o), .tout_o(tout_o), .cap_o(cap_o), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic expect_at(input int c, input int f, input int v, input string r);
    exp_t e;
    int i = 0;
    e.cyc = c; e.fld = f; e.val = v; e.req = r;
    while (i < exp_q.size() && exp_q[i].cyc <= c) i++;
    exp_q.insert(i, e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic start_timer(input logic [2:0] m, input logic p, input int r,
                             input int cv, output int t0);
    mode_i = m; pol_i = p; reload_i = 16'(r); cmp_i = 16'(cv);
    en_we_i = 1'b1; en_d_i = 1'b1;
    t0 = cyc + 1;
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  task automatic stop_timer();
    en_we_i = 1'b1; en_d_i = 1'b0;
    expect_at(cyc + 1, F_EN, 0, "R1");
    expect_at(cyc + 1, F_TOUT, int'(pol_i), "R1");
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  // monitor: pop due items and compare against the ports
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
        exp_t e;
        int act;
        e = exp_q.pop_front();
        case (e.fld)
          F_TOUT:  act = int'(tout_o);
          F_IRQ:   act = int'(irq_o);
          F_CAP:   act = int'(cap_o);
          default: act = int'(en_o);
        endcase
        checks++;
        if (e.cyc != cyc || act != e.val) begin
          errors++;
          $display("FAIL %s field %0d cycle %0d actual=%0d expected=%0d (due %0d)",
                   e.req, e.fld, cyc, act, e.val, e.cyc);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, a, c, d, e;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // reset state and idle level
    expect_at(cyc, F_TOUT, 0, "R1");
    expect_at(cyc, F_IRQ, 0, "R2");
    expect_at(cyc, F_CAP, 0, "R7");
    expect_at(cyc, F_EN, 0, "R2");
    tick(1);
    pol_i = 1'b1;
    expect_at(cyc, F_TOUT, 1, "R1");
    tick(2);

    // R3 one-shot, reload 4, polarity 0
    start_timer(3'd0, 1'b0, 4, 0, t0);
    expect_at(t0, F_EN, 1, "R2");
    expect_at(t0, F_TOUT, 0, "R3");
    expect_at(t0 + 3, F_IRQ, 0, "R2");
    expect_at(t0 + 3, F_TOUT, 0, "R3");
    expect_at(t0 + 4, F_IRQ, 1, "R3");
    expect_at(t0 + 4, F_TOUT, 1, "R3");
    expect_at(t0 + 4, F_EN, 0, "R3");
    expect_at(t0 + 5, F_TOUT, 0, "R3");
    expect_at(t0 + 5, F_IRQ, 0, "R3");
    tick(8);

    // R4 continuous, reload 3, polarity 1
    start_timer(3'd1, 1'b1, 3, 0, t0);
    expect_at(t0, F_TOUT, 1, "R4");
    expect_at(t0 + 3, F_TOUT, 0, "R4");
    expect_at(t0 + 3, F_IRQ, 1, "R2");
    expect_at(t0 + 4, F_IRQ, 0, "R2");
    expect_at(t0 + 6, F_TOUT, 1, "R4");
    expect_at(t0 + 6, F_IRQ, 1, "R2");
    tick(7);
    stop_timer();
    tick(2);

    // R4 compare mode, reload 2, polarity 0
    start_timer(3'd5, 1'b0, 2, 0, t0);
    expect_at(t0, F_TOUT, 0, "R4");
    expect_at(t0 + 2, F_TOUT, 1, "R4");
    expect_at(t0 + 2, F_IRQ, 1, "R2");
    expect_at(t0 + 3, F_IRQ, 0, "R2");
    expect_at(t0 + 4, F_TOUT, 0, "R4");
    tick(5);
    stop_timer();
    tick(2);

    // R6 PWM, reload 6, compare 2, polarity 1
    start_timer(3'd3, 1'b1, 6, 2, t0);
    expect_at(t0, F_TOUT, 0, "R6");
    expect_at(t0 + 1, F_TOUT, 0, "R6");
    expect_at(t0 + 2, F_TOUT, 1, "R6");
    expect_at(t0 + 2, F_IRQ, 0, "R6");
    expect_at(t0 + 5, F_TOUT, 1, "R6");
    expect_at(t0 + 6, F_TOUT, 0, "R6");
    expect_at(t0 + 6, F_IRQ, 1, "R6");
    expect_at(t0 + 8, F_TOUT, 1, "R6");
    tick(9);
    stop_timer();
    tick(2);

    // R7 capture on rising edges
    start_timer(3'd4, 1'b0, 1000, 0, t0);
    tick(5);
    c = cyc;
    tin_i = 1'b1;
    expect_at(c + 2, F_IRQ, 0, "R7");
    expect_at(c + 3, F_IRQ, 1, "R7");
    expect_at(c + 3, F_CAP, c + 3 - t0, "R7");
    tick(6);
    d = cyc;
    tin_i = 1'b0;
    expect_at(d + 3, F_IRQ, 0, "R7");
    expect_at(d + 3, F_CAP, c + 3 - t0, "R7");
    tick(5);
    stop_timer();
    tick(2);

    // R7 capture on falling edges
    a = c + 3 - t0;
    start_timer(3'd4, 1'b1, 1000, 0, t0);
    tick(4);
    c = cyc;
    tin_i = 1'b1;
    expect_at(c + 3, F_IRQ, 0, "R7");
    expect_at(c + 3, F_CAP, a, "R7");
    tick(4);
    d = cyc;
    tin_i = 1'b0;
    expect_at(d + 3, F_IRQ, 1, "R7");
    expect_at(d + 3, F_CAP, d + 3 - t0, "R7");
    tick(5);
    stop_timer();
    tick(2);

    // R5 counter on falling edges, reload 3
    start_timer(3'd2, 1'b1, 3, 0, t0);
    tick(2);
    a = cyc;
    expect_at(a + 19, F_IRQ, 0, "R5");
    expect_at(a + 19, F_TOUT, 1, "R5");
    expect_at(a + 23, F_IRQ, 1, "R5");
    expect_at(a + 23, F_TOUT, 0, "R5");
    for (int k = 0; k < 6; k++) begin
      tin_i = ~tin_i;
      tick(4);
    end
    tick(1);
    stop_timer();
    tick(2);

    // R8 gated, polarity 0, reload 5
    start_timer(3'd6, 1'b0, 5, 0, t0);
    tick(5);
    c = cyc;
    tin_i = 1'b1;
    expect_at(c + 3, F_IRQ, 0, "R8");
    expect_at(c + 6, F_IRQ, 0, "R8");
    expect_at(c + 7, F_IRQ, 1, "R8");
    expect_at(c + 7, F_TOUT, 1, "R8");
    tick(8);
    tin_i = 1'b0;
    expect_at(c + 10, F_IRQ, 0, "R8");
    expect_at(c + 11, F_IRQ, 1, "R8");
    expect_at(c + 11, F_TOUT, 1, "R8");
    expect_at(c + 12, F_IRQ, 0, "R8");
    tick(12);
    e = cyc;
    tin_i = 1'b1;
    expect_at(e + 3, F_IRQ, 0, "R8");
    expect_at(e + 4, F_IRQ, 1, "R8");
    expect_at(e + 4, F_TOUT, 0, "R8");
    tick(6);
    stop_timer();
    tin_i = 1'b0;
    tick(4);

    // R9 capture/compare, polarity 0
    a = int'(cap_o);
    start_timer(3'd7, 1'b0, 1000, 0, t0);
    tick(3);
    c = cyc;
    tin_i = 1'b1;
    expect_at(c + 3, F_IRQ, 0, "R9");
    expect_at(c + 3, F_CAP, a, "R9");
    tick(4);
    tin_i = 1'b0;
    expect_at(c + 7, F_IRQ, 0, "R9");
    tick(6);
    d = cyc;
    tin_i = 1'b1;
    expect_at(d + 3, F_IRQ, 1, "R9");
    expect_at(d + 3, F_CAP, d - c, "R9");
    tick(5);
    stop_timer();
    tick(2);

    while (exp_q.size() > 0) tick(1);
    tick(1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule